// File: doc/BRIEF.md
# CHR Bank and Mirroring Controller

This block sits behind the scanline-counting bank controller of a multicart mapper. It turns the 1 KiB pattern-table bank chosen by the inner controller for the current PPU slot into a full pattern ROM bank number. To do that it merges the bank with an outer bank taken from outer register 0. A board strap picks one of two wirings for the two highest outer address bits. When outer register 3 enables the fixed-8 KiB mode, the inner bank is set aside and outer register 2 supplies an 8 KiB bank instead.

The same block picks the nametable arrangement from three sources, in order of priority. The first is a single-screen mode whose page follows a bit of inner register R6. The second is an extended four-way select taken from the mirroring register. The last is the plain two-way select from that same register. All outputs are registered, so they appear one clock after the inputs.

Top module: `chr_mirror_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `chr_bank` = 0, `chr_unit_8k` = 0 and `mirror` = 2'b00.
- R2: Every output reflects the inputs sampled at the previous rising clock edge. A change of input between edges does not show until the next edge.
- R3: Outer register 0 bit 7 selects the inner bank mask. When the bit is set, only the low 7 bits of the inner bank pass through and bank bit 7 comes from the outer value. When the bit is clear, all 8 inner bits pass through.
- R4: With `swap_hi` = 0, the outer value has the following bits. Bit 7 is reg0 bit 3. Bit 8 is reg0 bit 4. Bit 9 is the inverse of reg0 bit 5. Bit 10 is reg0 bit 2. In 1 KiB mode, `chr_bank` = (inner AND mask) OR (outer AND NOT mask).
- R5: With `swap_hi` = 1, the outer value has the following bits. Bit 7 is reg0 bit 3. Bit 8 is the inverse of reg0 bit 5. Bit 9 is reg0 bit 4. Bit 10 is 0.
- R6: When reg3 bit 4 is set, `chr_unit_8k` = 1 and `chr_bank` = (reg2 AND (mask >> 3)) OR ((outer AND NOT mask) >> 3). In this mode the inner bank value has no effect.
- R7: When reg3 bit 5 is set, `mirror` is single-screen: 2'b11 if R6 bit 4 is set, else 2'b10. This takes priority over every other mirroring source.
- R8: When reg3 bit 5 is clear and reg1 bit 1 is set, `mirror` equals bits 1:0 of the mirroring register. The encoding is 00 vertical, 01 horizontal, 10 single lower, 11 single upper.
- R9: Otherwise `mirror` is 2'b01 (horizontal) when bit 0 of the mirroring register is set, and 2'b00 (vertical) when it is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| swap_hi | input | 1 | Board strap: alternate wiring of outer bank bits 8 and 9 |
| inner_bank | input | 8 | 1 KiB bank from the inner controller for the current slot |
| reg0 | input | 8 | Outer register 0 (mask size, outer bank bits) |
| reg1 | input | 8 | Outer register 1 (bit 1: extended mirroring) |
| reg2 | input | 8 | Outer register 2 (8 KiB bank in fixed mode) |
| reg3 | input | 8 | Outer register 3 (bit 4: 8 KiB mode, bit 5: single-screen) |
| r6 | input | 8 | Inner register R6 (bit 4: single-screen page) |
| mirror_reg | input | 8 | Stored mirroring register |
| chr_bank | output | 11 | Pattern ROM bank number |
| chr_unit_8k | output | 1 | 1 when chr_bank is in 8 KiB units |
| mirror | output | 2 | Nametable arrangement code |

## Verification
Suppose the mask decode or the outer bit wiring is wrong. The error shows on `chr_bank` one clock after the first reg0 value that exercises the wrong bit, so the bench sweeps all reg0 values under both wirings and both bank modes. A wrong mirroring priority shows on `mirror` one clock after a conflicting set of source bits. An exhaustive sweep of the five deciding bits exposes it. Latency faults show as an output that changes before the edge or lags by one extra cycle.

// File: rtl/chr_mirror_pkg.sv
package chr_mirror_pkg;
  parameter int INNER_W  = 8;
  parameter int BANK_W   = 11;
  parameter int UNIT8_SH = 3;

  localparam int R0_NARROW = 7;
  localparam int R0_SWAPPED_A = 3;
  localparam int R0_INV_BIT = 5;
  localparam int R0_MID_BIT = 4;
  localparam int R0_TOP_BIT = 2;
  localparam int R1_EXT_MIR = 1;
  localparam int R3_UNIT8K = 4;
  localparam int R3_SINGLE = 5;
  localparam int R6_PAGE = 4;

  typedef enum logic [1:0] {
    MIR_VERT   = 2'b00,
    MIR_HORZ   = 2'b01,
    MIR_SC_LO  = 2'b10,
    MIR_SC_HI  = 2'b11
  } mirror_t;
endpackage

// File: rtl/chr_outer_map.sv
module chr_outer_map
  import chr_mirror_pkg::*;
#(
  parameter int IW = INNER_W,
  parameter int BW = BANK_W
) (
  input  logic [7:0]    reg0,
  input  logic          swap_hi,
  output logic [BW-1:0] mask,
  output logic [BW-1:0] outer
);
  localparam logic [BW-1:0] WIDE_MASK   = BW'((1 << IW) - 1);
  localparam logic [BW-1:0] NARROW_MASK = BW'((1 << (IW - 1)) - 1);

  logic [BW-1:0] raw;

  always_comb begin
    mask = reg0[R0_NARROW] ? NARROW_MASK : WIDE_MASK;
    raw  = '0;
    raw[IW-1] = reg0[R0_SWAPPED_A];
    if (swap_hi) begin
      raw[IW]   = ~reg0[R0_INV_BIT];
      raw[IW+1] = reg0[R0_MID_BIT];
    end else begin
      raw[IW]   = reg0[R0_MID_BIT];
      raw[IW+1] = ~reg0[R0_INV_BIT];
      raw[IW+2] = reg0[R0_TOP_BIT];
    end
    outer = raw & ~mask;
  end
endmodule

// File: rtl/chr_bank_sel.sv
module chr_bank_sel
  import chr_mirror_pkg::*;
#(
  parameter int IW = INNER_W,
  parameter int BW = BANK_W,
  parameter int SH = UNIT8_SH
) (
  input  logic [IW-1:0] inner_bank,
  input  logic [7:0]    reg2,
  input  logic          unit8_en,
  input  logic [BW-1:0] mask,
  input  logic [BW-1:0] outer,
  output logic [BW-1:0] bank,
  output logic          unit8
);
  logic [BW-1:0] fine_bank;
  logic [BW-1:0] coarse_bank;

  always_comb begin
    fine_bank   = (BW'(inner_bank) & mask) | outer;
    coarse_bank = (BW'(reg2) & (mask >> SH)) | (outer >> SH);
    bank  = unit8_en ? coarse_bank : fine_bank;
    unit8 = unit8_en;
  end
endmodule

// File: rtl/chr_mirror_sel.sv
module chr_mirror_sel
  import chr_mirror_pkg::*;
(
  input  logic [7:0] reg1,
  input  logic [7:0] reg3,
  input  logic [7:0] r6,
  input  logic [7:0] mirror_reg,
  output mirror_t    mode
);
  always_comb begin
    if (reg3[R3_SINGLE])
      mode = r6[R6_PAGE] ? MIR_SC_HI : MIR_SC_LO;
    else if (reg1[R1_EXT_MIR])
      mode = mirror_t'(mirror_reg[1:0]);
    else
      mode = mirror_reg[0] ? MIR_HORZ : MIR_VERT;
  end
endmodule

// File: rtl/chr_mirror_ctrl.sv
module chr_mirror_ctrl
  import chr_mirror_pkg::*;
#(
  parameter int IW = INNER_W,
  parameter int BW = BANK_W,
  parameter int SH = UNIT8_SH
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          swap_hi,
  input  logic [IW-1:0] inner_bank,
  input  logic [7:0]    reg0,
  input  logic [7:0]    reg1,
  input  logic [7:0]    reg2,
  input  logic [7:0]    reg3,
  input  logic [7:0]    r6,
  input  logic [7:0]    mirror_reg,
  output logic [BW-1:0] chr_bank,
  output logic          chr_unit_8k,
  output logic [1:0]    mirror
);
  logic [BW-1:0] mask_c;
  logic [BW-1:0] outer_c;
  logic [BW-1:0] bank_c;
  logic          unit8_c;
  mirror_t       mode_c;
  logic          primed;

  chr_outer_map #(.IW(IW), .BW(BW)) u_outer (
    .reg0    (reg0),
    .swap_hi (swap_hi),
    .mask    (mask_c),
    .outer   (outer_c)
  );

  chr_bank_sel #(.IW(IW), .BW(BW), .SH(SH)) u_bank (
    .inner_bank (inner_bank),
    .reg2       (reg2),
    .unit8_en   (reg3[R3_UNIT8K]),
    .mask       (mask_c),
    .outer      (outer_c),
    .bank       (bank_c),
    .unit8      (unit8_c)
  );

  chr_mirror_sel u_mirror (
    .reg1       (reg1),
    .reg3       (reg3),
    .r6         (r6),
    .mirror_reg (mirror_reg),
    .mode       (mode_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      chr_bank    <= '0;
      chr_unit_8k <= 1'b0;
      mirror      <= MIR_VERT;
      primed      <= 1'b0;
    end else begin
      chr_bank    <= bank_c;
      chr_unit_8k <= unit8_c;
      mirror      <= mode_c;
      primed      <= 1'b1;
    end
  end

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (chr_bank == '0 && !chr_unit_8k && mirror == 2'b00));

  assert_inner_pass_R3: assert property (@(posedge clk) disable iff (rst)
    (primed && !$past(reg3[R3_UNIT8K]) && !$past(reg0[R0_NARROW]))
      |-> chr_bank[IW-1:0] == $past(inner_bank));

  assert_swap_top_R5: assert property (@(posedge clk) disable iff (rst)
    (primed && !$past(reg3[R3_UNIT8K]) && $past(swap_hi))
      |-> chr_bank[BW-1] == 1'b0);

  assert_unit8_hi_R6: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(reg3[R3_UNIT8K]))
      |-> (chr_unit_8k && chr_bank[BW-1:IW] == '0));

  assert_single_R7: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(reg3[R3_SINGLE]))
      |-> mirror == {1'b1, $past(r6[R6_PAGE])});

  assert_ext_R8: assert property (@(posedge clk) disable iff (rst)
    (primed && !$past(reg3[R3_SINGLE]) && $past(reg1[R1_EXT_MIR]))
      |-> mirror == $past(mirror_reg[1:0]));

  assert_plain_R9: assert property (@(posedge clk) disable iff (rst)
    (primed && !$past(reg3[R3_SINGLE]) && !$past(reg1[R1_EXT_MIR]))
      |-> mirror == {1'b0, $past(mirror_reg[0])});
endmodule

// File: tb/tb_chr_mirror_ctrl.sv
module tb_chr_mirror_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        swap_hi = 1'b0;
  logic [7:0]  inner_bank = '0;
  logic [7:0]  reg0 = '0, reg1 = '0, reg2 = '0, reg3 = '0, r6 = '0, mirror_reg = '0;
  logic [10:0] chr_bank;
  logic        chr_unit_8k;
  logic [1:0]  mirror;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  chr_mirror_ctrl dut (
    .clk(clk), .rst(rst), .swap_hi(swap_hi), .inner_bank(inner_bank),
    .reg0(reg0), .reg1(reg1), .reg2(reg2), .reg3(reg3), .r6(r6),
    .mirror_reg(mirror_reg), .chr_bank(chr_bank), .chr_unit_8k(chr_unit_8k),
    .mirror(mirror)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int outer_of(input int r0, input bit sw);
    int v;
    if (sw)
      v = ((r0 >> 3) & 1) * 128 + (1 - ((r0 >> 5) & 1)) * 256 + ((r0 >> 4) & 1) * 512;
    else
      v = ((r0 >> 3) & 1) * 128 + ((r0 >> 4) & 1) * 256 + (1 - ((r0 >> 5) & 1)) * 512
          + ((r0 >> 2) & 1) * 1024;
    return v;
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int bvals[4] = '{8'h00, 8'hFF, 8'hA5, 8'h5A};
    reg0 = 8'hFF; reg3 = 8'h30; mirror_reg = 8'h03; inner_bank = 8'hFF;
    step(); step();
    check("R1 bank", chr_bank, 0);
    check("R1 unit", chr_unit_8k, 0);
    check("R1 mirror", mirror, 0);
    @(negedge clk); rst = 1'b0;

    // R2: output changes only at the edge
    @(negedge clk);
    reg0 = 8'h00; reg3 = 8'h00; inner_bank = 8'h12; swap_hi = 0;
    step();
    check("R2 after edge", chr_bank, outer_of(0, 0) | 8'h12);
    @(negedge clk);
    inner_bank = 8'h34;
    #2;
    check("R2 before edge", chr_bank, outer_of(0, 0) | 8'h12);
    step();
    check("R2 next edge", chr_bank, outer_of(0, 0) | 8'h34);

    // R3 R4 R5 R6: sweep reg0, wiring, mode and several bank values
    for (int sw = 0; sw < 2; sw++)
      for (int cn = 0; cn < 2; cn++)
        for (int r0 = 0; r0 < 256; r0++)
          for (int bi = 0; bi < 4; bi++) begin
            int msk, oth, exp;
            @(negedge clk);
            swap_hi = sw[0]; reg0 = r0[7:0]; inner_bank = bvals[bi][7:0];
            reg2 = ~bvals[bi][7:0]; reg3 = cn ? 8'h10 : 8'h00;
            msk = (r0 & 128) ? 127 : 255;
            oth = outer_of(r0, sw[0]) & ~msk & 11'h7FF;
            step();
            if (cn) begin
              exp = ((~bvals[bi] & 255) & (msk >> 3)) | (oth >> 3);
              check("R6 bank", chr_bank, exp);
              check("R6 unit", chr_unit_8k, 1);
            end else begin
              exp = (bvals[bi] & msk) | oth;
              check(sw ? "R3 R5 bank" : "R3 R4 bank", chr_bank, exp);
              check("R6 unit off", chr_unit_8k, 0);
            end
          end

    // R6: inner bank has no effect in 8 KiB mode
    @(negedge clk);
    swap_hi = 0; reg0 = 8'h00; reg2 = 8'h07; reg3 = 8'h10; inner_bank = 8'h00;
    step();
    check("R6 base", chr_bank, 7 | (outer_of(0, 0) >> 3));
    @(negedge clk); inner_bank = 8'hFF;
    step();
    check("R6 inner ignored", chr_bank, 7 | (outer_of(0, 0) >> 3));

    // R7 R8 R9: all deciding bits of the mirroring sources
    for (int k = 0; k < 32; k++) begin
      int exp;
      @(negedge clk);
      reg3 = (k & 1) ? 8'h20 : 8'h00;
      r6 = (k & 2) ? 8'h10 : 8'h00;
      reg1 = (k & 4) ? 8'h02 : 8'h00;
      mirror_reg = 8'(k >> 3) | 8'hF0;
      step();
      if (k & 1) begin
        exp = (k & 2) ? 3 : 2;
        check("R7 single", mirror, exp);
      end else if (k & 4) begin
        exp = (k >> 3) & 3;
        check("R8 extended", mirror, exp);
      end else begin
        exp = (k >> 3) & 1;
        check("R9 plain", mirror, exp);
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule